// File: doc/BRIEF.md
# Multi-Stream Acquisition Write DMA

This block drains byte-counted sample data from several input streams into memory, one transfer at a time. A transfer request names a stream, a start byte address and a maximum byte count. The engine reads 64-bit beats from the chosen stream, packs their valid bytes into a staging buffer with no gaps, and then posts one write request (address and size) on a memory request channel. The packed data follows on a separate memory data channel. A response closes every transfer and reports the stream, the number of bytes that were actually moved and the reason the transfer ended.

If the byte limit is reached partway through a beat, the rest of that beat is kept in a per-stream holding slot, along with the beat's end flags. The next transfer on that stream starts with those held bytes, at its own start address. A beat with zero valid bytes that carries both the frame-end and timeout flags closes a transfer early. When such a transfer moved nothing, no write request and no write data are issued; only the response appears, reporting zero bytes.

The write request is posted only after the final size is known. For that reason a single transfer may not exceed the staging buffer, which holds BUF_BEATS beats of 8 bytes.

Top module: `acq_wdma`

## Requirements
- R1: Valid bytes of an input beat occupy its low-order byte lanes (lane 0 = bits 7:0), with count 0 to 8 in the 4-bit byte count. Memory data carries the transferred bytes in stream order from lane 0 of the first beat upward. Every data beat except the final one is fully packed, and lanes beyond the valid count of an input beat are ignored.
- R2: A request is accepted only while the engine is idle; `cmd_rdy` stays low from acceptance until the response handshake. The response echoes the request's stream number.
- R3: A transfer that reaches its maximum byte count ends there with end code 0 (none), and the response reports the number of bytes moved.
- R4: Bytes beyond the limit in a partially used beat are held for that stream and are written first by the next request on that stream, starting at that request's address.
- R5: A zero-byte beat with frame-end and timeout set ends the transfer with end code 2 (timeout); its data lanes are ignored.
- R6: A transfer that moves zero bytes (a zero-byte timeout beat with nothing pending, or a maximum of 0) produces no memory write request and no memory data, and its response reports 0 bytes.
- R7: A beat with frame-end set that is fully consumed ends the transfer with end code 1 (trigger) or 2 (timeout, when its timeout flag is set). A frame-end on a partially consumed beat takes effect when its held remainder is consumed.
- R8: Each non-empty transfer issues exactly one memory write request, carrying the request's start address and a size equal to the response byte count.
- R9: Every output valid (write request, write data, response) stays high, with its payload unchanged, until the matching ready is seen.
- R10: Held bytes belong to one stream; a transfer on another stream neither uses nor disturbs them.
- R11: Synchronous reset leaves `cmd_rdy` high, all output valids and input readies low, and every stream's held bytes discarded.
- R12: `md_last` is high on the final data beat of a transfer and low on all others.
- R13: At most one input ready is high at a time, and only the one for the stream being served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_vld | input | 1 | Transfer request valid |
| cmd_rdy | output | 1 | Transfer request accepted |
| cmd_stream | input | SEL_W | Stream to drain |
| cmd_addr | input | ADDR_W | Start byte address |
| cmd_max | input | SIZE_W | Maximum byte count (at most BUF_BEATS*8) |
| in_vld | input | STREAMS | Beat valid, one bit per stream |
| in_rdy | output | STREAMS | Beat accepted, one bit per stream |
| in_data | input | STREAMS*64 | Beat data, 64 bits per stream |
| in_nbytes | input | STREAMS*4 | Valid byte count per stream |
| in_last | input | STREAMS | Frame end flag per stream |
| in_tmo | input | STREAMS | Frame ended by timeout |
| in_trig | input | STREAMS | Frame ended by trigger |
| mc_vld | output | 1 | Memory write request valid |
| mc_rdy | input | 1 | Memory write request accepted |
| mc_addr | output | ADDR_W | Write start address |
| mc_size | output | SIZE_W | Write size in bytes |
| md_vld | output | 1 | Write data valid |
| md_rdy | input | 1 | Write data accepted |
| md_data | output | 64 | Packed write data |
| md_last | output | 1 | Final data beat of the write |
| rsp_vld | output | 1 | Response valid |
| rsp_rdy | input | 1 | Response accepted |
| rsp_stream | output | SEL_W | Stream of the finished transfer |
| rsp_bytes | output | SIZE_W | Bytes moved |
| rsp_end | output | 2 | End reason: 0 none, 1 trigger, 2 timeout |

## Verification
The packing path is swept with every input beat size from 1 to 8 against a set of byte limits below, equal to and across beat and 8-byte boundaries, with the two streams alternating. This sweep separates correct lane alignment, leftover carry and per-stream isolation from off-by-one and cross-stream faults. Directed sequences then contrast a zero-byte timeout beat with and without held bytes, a zero limit, frame ends by trigger and by timeout on whole and split beats, a transfer that fills the staging buffer, and a reset taken while bytes are held. Ready signals on all output channels and valid on the inputs toggle pseudo-randomly, so handshake stalls are seen throughout.

// File: rtl/acq_wdma_pkg.sv
package acq_wdma_pkg;

    localparam int BEAT_BYTES = 8;
    localparam int BEAT_W     = 8 * BEAT_BYTES;
    localparam int NB_W       = 4;

    typedef enum logic [1:0] {
        END_NONE = 2'd0,
        END_TRIG = 2'd1,
        END_TMO  = 2'd2
    } end_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COLLECT,
        ST_FLUSH,
        ST_MCMD,
        ST_MDAT,
        ST_RESP
    } st_t;

    typedef struct packed {
        logic [BEAT_W-1:0] data;
        logic [NB_W-1:0]   nb;
        logic              last;
        logic              tmo;
        logic              trig;
    } beat_t;

    // zero every lane at or above the byte count
    function automatic logic [BEAT_W-1:0] keep_low(input logic [BEAT_W-1:0] d,
                                                   input logic [NB_W-1:0]   n);
        logic [BEAT_W-1:0] m;
        m = '0;
        for (int i = 0; i < BEAT_BYTES; i++) begin
            if (i < int'(n)) m[i*8 +: 8] = 8'hFF;
        end
        return d & m;
    endfunction

    function automatic end_t end_of(input beat_t b);
        return b.tmo ? END_TMO : END_TRIG;
    endfunction

endpackage

// File: rtl/acq_wdma_lobank.sv
module acq_wdma_lobank
    import acq_wdma_pkg::*;
#(
    parameter int STREAMS = 2,
    parameter int SEL_W   = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  beat_t            wr_beat,
    input  logic [SEL_W-1:0] rd_sel,
    output beat_t            rd_beat
);

    beat_t slot [STREAMS];

    for (genvar g = 0; g < STREAMS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot[g] <= '0;
            end else if (wr_en && wr_sel == SEL_W'(g)) begin
                slot[g] <= wr_beat;
            end
        end
    end

    assign rd_beat = slot[rd_sel];

endmodule

// File: rtl/acq_wdma_wbuf.sv
module acq_wdma_wbuf
    import acq_wdma_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [BEAT_W-1:0] wdata,
    input  logic              pop,
    output logic [BEAT_W-1:0] rdata,
    output logic              empty,
    output logic              last_one
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [BEAT_W-1:0] mem [DEPTH];
    logic [PW:0]       wr_ptr, rd_ptr, fill;

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr[PW-1:0]] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
        end
    end

    assign fill     = wr_ptr - rd_ptr;
    assign rdata    = mem[rd_ptr[PW-1:0]];
    assign empty    = (fill == '0);
    assign last_one = (fill == (PW+1)'(1));

endmodule

// File: rtl/acq_wdma.sv
module acq_wdma
    import acq_wdma_pkg::*;
#(
    parameter int STREAMS   = 2,
    parameter int ADDR_W    = 32,
    parameter int SIZE_W    = 16,
    parameter int BUF_BEATS = 8,
    localparam int SEL_W    = (STREAMS > 1) ? $clog2(STREAMS) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cmd_vld,
    output logic                      cmd_rdy,
    input  logic [SEL_W-1:0]          cmd_stream,
    input  logic [ADDR_W-1:0]         cmd_addr,
    input  logic [SIZE_W-1:0]         cmd_max,
    input  logic [STREAMS-1:0]        in_vld,
    output logic [STREAMS-1:0]        in_rdy,
    input  logic [STREAMS*BEAT_W-1:0] in_data,
    input  logic [STREAMS*NB_W-1:0]   in_nbytes,
    input  logic [STREAMS-1:0]        in_last,
    input  logic [STREAMS-1:0]        in_tmo,
    input  logic [STREAMS-1:0]        in_trig,
    output logic                      mc_vld,
    input  logic                      mc_rdy,
    output logic [ADDR_W-1:0]         mc_addr,
    output logic [SIZE_W-1:0]         mc_size,
    output logic                      md_vld,
    input  logic                      md_rdy,
    output logic [BEAT_W-1:0]         md_data,
    output logic                      md_last,
    output logic                      rsp_vld,
    input  logic                      rsp_rdy,
    output logic [SEL_W-1:0]          rsp_stream,
    output logic [SIZE_W-1:0]         rsp_bytes,
    output logic [1:0]                rsp_end
);

    localparam int ACC_W = 2 * BEAT_W;

    st_t               st;
    logic [SEL_W-1:0]  sel_q;
    logic [ADDR_W-1:0] addr_q;
    logic [SIZE_W-1:0] max_q, rem_q, rem_next, total;
    end_t              end_q, fin_end;
    logic [ACC_W-1:0]  acc_q, merged;
    logic [3:0]        acc_cnt_q, take;
    logic [4:0]        sum;

    beat_t lo_beat, in_beat, src, rest, lo_wb;
    logic  use_lo, src_vld, collecting, fire, partial, finish, lo_we;
    logic  buf_push, buf_pop, buf_empty, buf_last;
    logic [BEAT_W-1:0] buf_wdata;

    // ---------------- source selection: held bytes first ----------------
    always_comb begin
        in_beat = '{data: in_data[sel_q*BEAT_W +: BEAT_W],
                    nb:   in_nbytes[sel_q*NB_W +: NB_W],
                    last: in_last[sel_q],
                    tmo:  in_tmo[sel_q],
                    trig: in_trig[sel_q]};
    end

    assign use_lo     = (lo_beat.nb != '0);
    assign src        = use_lo ? lo_beat : in_beat;
    assign src_vld    = use_lo | in_vld[sel_q];
    assign collecting = (st == ST_COLLECT) && (rem_q != '0);
    assign fire       = collecting && src_vld;

    always_comb begin
        in_rdy = '0;
        if (collecting && !use_lo) in_rdy[sel_q] = 1'b1;
    end

    // ---------------- byte packing ----------------
    assign take     = (rem_q < SIZE_W'(src.nb)) ? rem_q[3:0] : src.nb;
    assign partial  = (take != src.nb);
    assign rem_next = rem_q - SIZE_W'(take);
    assign sum      = {1'b0, acc_cnt_q} + {1'b0, take};
    assign merged   = acc_q | (ACC_W'(keep_low(src.data, take)) << {acc_cnt_q, 3'b000});

    always_comb begin
        rest      = src;
        rest.data = src.data >> {take, 3'b000};
        rest.nb   = src.nb - take;
    end

    assign finish  = partial || src.last || (rem_next == '0);
    assign fin_end = (!partial && src.last) ? end_of(src) : END_NONE;
    assign lo_we   = fire && (partial || use_lo);
    assign lo_wb   = partial ? rest : '0;

    assign buf_push  = (fire && sum >= 5'd8) || (st == ST_FLUSH && acc_cnt_q != '0);
    assign buf_wdata = (st == ST_FLUSH) ? acc_q[BEAT_W-1:0] : merged[BEAT_W-1:0];
    assign buf_pop   = md_vld && md_rdy;
    assign total     = max_q - rem_q;

    acq_wdma_lobank #(.STREAMS(STREAMS), .SEL_W(SEL_W)) u_lobank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (lo_we),
        .wr_sel  (sel_q),
        .wr_beat (lo_wb),
        .rd_sel  (sel_q),
        .rd_beat (lo_beat)
    );

    acq_wdma_wbuf #(.DEPTH(BUF_BEATS)) u_wbuf (
        .clk      (clk),
        .rst      (rst),
        .push     (buf_push),
        .wdata    (buf_wdata),
        .pop      (buf_pop),
        .rdata    (md_data),
        .empty    (buf_empty),
        .last_one (buf_last)
    );

    // ---------------- sequencing ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            sel_q     <= '0;
            addr_q    <= '0;
            max_q     <= '0;
            rem_q     <= '0;
            end_q     <= END_NONE;
            acc_q     <= '0;
            acc_cnt_q <= '0;
        end else begin
            case (st)
                ST_IDLE: if (cmd_vld) begin
                    sel_q  <= cmd_stream;
                    addr_q <= cmd_addr;
                    max_q  <= cmd_max;
                    rem_q  <= cmd_max;
                    st     <= ST_COLLECT;
                end
                ST_COLLECT: begin
                    if (rem_q == '0) begin
                        end_q <= END_NONE;
                        st    <= ST_FLUSH;
                    end else if (src_vld) begin
                        rem_q <= rem_next;
                        if (sum >= 5'd8) begin
                            acc_q     <= merged >> BEAT_W;
                            acc_cnt_q <= 4'(sum - 5'd8);
                        end else begin
                            acc_q     <= merged;
                            acc_cnt_q <= sum[3:0];
                        end
                        if (finish) begin
                            end_q <= fin_end;
                            st    <= ST_FLUSH;
                        end
                    end
                end
                ST_FLUSH: begin
                    acc_q     <= '0;
                    acc_cnt_q <= '0;
                    st        <= (total != '0) ? ST_MCMD : ST_RESP;
                end
                ST_MCMD: if (mc_rdy) st <= ST_MDAT;
                ST_MDAT: if (buf_pop && buf_last) st <= ST_RESP;
                ST_RESP: if (rsp_rdy) st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign cmd_rdy    = (st == ST_IDLE);
    assign mc_vld     = (st == ST_MCMD);
    assign mc_addr    = addr_q;
    assign mc_size    = total;
    assign md_vld     = (st == ST_MDAT) && !buf_empty;
    assign md_last    = buf_last;
    assign rsp_vld    = (st == ST_RESP);
    assign rsp_stream = sel_q;
    assign rsp_bytes  = total;
    assign rsp_end    = end_q;

endmodule

// File: rtl/acq_wdma_chk.sv
module acq_wdma_chk #(
    parameter int STREAMS = 2,
    parameter int ADDR_W  = 32,
    parameter int SIZE_W  = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               cmd_rdy,
    input logic [STREAMS-1:0] in_rdy,
    input logic               mc_vld,
    input logic               mc_rdy,
    input logic [ADDR_W-1:0]  mc_addr,
    input logic [SIZE_W-1:0]  mc_size,
    input logic               md_vld,
    input logic               md_rdy,
    input logic [63:0]        md_data,
    input logic               md_last,
    input logic               rsp_vld,
    input logic               rsp_rdy,
    input logic [SIZE_W-1:0]  rsp_bytes,
    input logic [1:0]         rsp_end
);

    assert_mcmd_hold_R9: assert property (@(posedge clk) disable iff (rst)
        mc_vld && !mc_rdy |=> mc_vld && $stable(mc_addr) && $stable(mc_size));

    assert_mdat_hold_R9: assert property (@(posedge clk) disable iff (rst)
        md_vld && !md_rdy |=> md_vld && $stable(md_data) && $stable(md_last));

    assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (rst)
        rsp_vld && !rsp_rdy |=> rsp_vld && $stable(rsp_bytes) && $stable(rsp_end));

    assert_no_empty_write_R6: assert property (@(posedge clk) disable iff (rst)
        mc_vld |-> mc_size != '0);

    assert_single_ready_R13: assert property (@(posedge clk) disable iff (rst)
        $onehot0(in_rdy));

    assert_idle_only_R2: assert property (@(posedge clk) disable iff (rst)
        cmd_rdy |-> !mc_vld && !md_vld && !rsp_vld && in_rdy == '0);

    assert_end_code_R7: assert property (@(posedge clk) disable iff (rst)
        rsp_vld |-> rsp_end != 2'd3);

endmodule

bind acq_wdma acq_wdma_chk #(
    .STREAMS (STREAMS),
    .ADDR_W  (ADDR_W),
    .SIZE_W  (SIZE_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_rdy   (cmd_rdy),
    .in_rdy    (in_rdy),
    .mc_vld    (mc_vld),
    .mc_rdy    (mc_rdy),
    .mc_addr   (mc_addr),
    .mc_size   (mc_size),
    .md_vld    (md_vld),
    .md_rdy    (md_rdy),
    .md_data   (md_data),
    .md_last   (md_last),
    .rsp_vld   (rsp_vld),
    .rsp_rdy   (rsp_rdy),
    .rsp_bytes (rsp_bytes),
    .rsp_end   (rsp_end)
);

// File: tb/acq_wdma_test.sv
module acq_wdma_test;
    import acq_wdma_pkg::*;

    localparam int NS = 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cmd_vld = 1'b0;
    logic              cmd_rdy;
    logic [0:0]        cmd_stream = '0;
    logic [31:0]       cmd_addr = '0;
    logic [15:0]       cmd_max = '0;
    logic [NS-1:0]     in_vld = '0;
    logic [NS-1:0]     in_rdy;
    logic [NS*64-1:0]  in_data = '0;
    logic [NS*4-1:0]   in_nbytes = '0;
    logic [NS-1:0]     in_last = '0, in_tmo = '0, in_trig = '0;
    logic              mc_vld, mc_rdy = 1'b0;
    logic [31:0]       mc_addr;
    logic [15:0]       mc_size;
    logic              md_vld, md_rdy = 1'b0, md_last;
    logic [63:0]       md_data;
    logic              rsp_vld, rsp_rdy = 1'b0;
    logic [0:0]        rsp_stream;
    logic [15:0]       rsp_bytes;
    logic [1:0]        rsp_end;

    always #10 clk = ~clk;

    acq_wdma #(.STREAMS(NS), .ADDR_W(32), .SIZE_W(16), .BUF_BEATS(8)) uut (
        .clk(clk), .rst(rst),
        .cmd_vld(cmd_vld), .cmd_rdy(cmd_rdy), .cmd_stream(cmd_stream),
        .cmd_addr(cmd_addr), .cmd_max(cmd_max),
        .in_vld(in_vld), .in_rdy(in_rdy), .in_data(in_data), .in_nbytes(in_nbytes),
        .in_last(in_last), .in_tmo(in_tmo), .in_trig(in_trig),
        .mc_vld(mc_vld), .mc_rdy(mc_rdy), .mc_addr(mc_addr), .mc_size(mc_size),
        .md_vld(md_vld), .md_rdy(md_rdy), .md_data(md_data), .md_last(md_last),
        .rsp_vld(rsp_vld), .rsp_rdy(rsp_rdy), .rsp_stream(rsp_stream),
        .rsp_bytes(rsp_bytes), .rsp_end(rsp_end)
    );

    typedef struct {
        logic [63:0] d;
        int          n;
        bit          last, tmo, trig;
    } tb_beat_t;

    tb_beat_t        dq [NS][$];
    tb_beat_t        mq [NS][$];
    logic [7:0]      exp_b [$];
    logic [7:0]      cap_b [$];
    bit              cap_last [$];
    int              n_chk = 0, n_bad = 0;
    int              pat [NS];
    int              mc_cnt = 0, rsp_cnt = 0;
    logic [31:0]     mc_a;
    logic [15:0]     mc_s, rsp_b;
    logic [1:0]      rsp_e;
    logic [0:0]      rsp_s;
    int              hold_bad = 0, rdy_bad = 0, busy_bad = 0;
    bit              busy = 0, done = 0;
    logic [NS-1:0]   cur_mask = '0;
    logic [15:0]     lfsr = 16'hACE1;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // beat with n valid bytes; lanes above n hold junk that must be ignored (R1, R5)
    task automatic push_beat(input int s, input int n, input bit last, input bit tmo, input bit trig);
        tb_beat_t b;
        b.d = 64'hA5A5_A5A5_A5A5_A5A5;
        for (int i = 0; i < 8; i++) begin
            if (i < n) begin
                b.d[i*8 +: 8] = 8'(pat[s]) ^ ((s == 1) ? 8'h80 : 8'h00);
                pat[s]++;
            end
        end
        b.n = n; b.last = last; b.tmo = tmo; b.trig = trig;
        dq[s].push_back(b);
        mq[s].push_back(b);
    endtask

    function automatic int pending(input int s);
        int p = 0;
        foreach (mq[s][i]) p += mq[s][i].n;
        return p;
    endfunction

    // expected outcome of one request, from the requirements
    task automatic model_cmd(input int s, input int max, output int total, output int en);
        int rem = max;
        en = 0;
        exp_b.delete();
        while (rem > 0) begin
            tb_beat_t h;
            int take;
            if (mq[s].size() == 0) begin en = 3; break; end
            h = mq[s][0];
            take = (h.n < rem) ? h.n : rem;
            for (int i = 0; i < take; i++) exp_b.push_back(h.d[i*8 +: 8]);
            rem -= take;
            if (take < h.n) begin
                mq[s][0].d = h.d >> (take * 8);
                mq[s][0].n = h.n - take;
                en = 0;
                break;
            end
            void'(mq[s].pop_front());
            if (h.last) begin en = h.tmo ? 2 : 1; break; end
        end
        total = max - rem;
    endtask

    task automatic run_cmd(input int s, input logic [31:0] addr, input int max, input string tag);
        int total, en, mc0, r0, nb, bad, lbad;
        model_cmd(s, max, total, en);
        cap_b.delete();
        cap_last.delete();
        mc0 = mc_cnt;
        r0  = rsp_cnt;
        @(posedge clk); #2;
        cmd_vld = 1'b1; cmd_stream = 1'(s); cmd_addr = addr; cmd_max = 16'(max);
        cur_mask = NS'(1) << s;
        do @(negedge clk); while (!cmd_rdy);
        @(posedge clk); #2;
        cmd_vld = 1'b0;
        busy = 1;
        while (rsp_cnt == r0) @(negedge clk);
        chk(rsp_b == 16'(total), {tag, " R3 response byte count"}, rsp_b, total);
        chk(rsp_e == 2'(en), {tag, " R7 end code"}, rsp_e, en);
        chk(rsp_s == 1'(s), {tag, " R2 stream echo"}, rsp_s, s);
        if (total == 0) begin
            chk(mc_cnt == mc0, {tag, " R6 no write request"}, mc_cnt - mc0, 0);
            chk(cap_b.size() == 0, {tag, " R6 no write data"}, cap_b.size(), 0);
        end else begin
            nb = (total + 7) / 8;
            chk(mc_cnt == mc0 + 1, {tag, " R8 one write request"}, mc_cnt - mc0, 1);
            chk(mc_a == addr, {tag, " R8 write address"}, mc_a, addr);
            chk(mc_s == 16'(total), {tag, " R8 write size"}, mc_s, total);
            chk(cap_last.size() == nb, {tag, " R1 data beat count"}, cap_last.size(), nb);
            bad = 0; lbad = 0;
            for (int i = 0; i < total; i++)
                if (i >= cap_b.size() || cap_b[i] !== exp_b[i]) bad++;
            foreach (cap_last[i]) if (cap_last[i] != (i == nb - 1)) lbad++;
            chk(bad == 0, {tag, " R1/R4/R10 byte order"}, bad, 0);
            chk(lbad == 0, {tag, " R12 last marker"}, lbad, 0);
        end
    endtask

    // monitor, sampling half a period away from the active edge
    logic        pm_wait = 0, pd_wait = 0;
    logic [31:0] pm_a;
    logic [15:0] pm_s;
    logic [63:0] pd_d;
    logic        pd_l;
    always @(negedge clk) begin
        if (!rst) begin
            if (cmd_rdy && busy) busy_bad++;
            if ($countones(in_rdy) > 1 || (in_rdy & ~cur_mask) != '0) rdy_bad++;
            if (pm_wait && !(mc_vld && mc_addr == pm_a && mc_size == pm_s)) hold_bad++;
            if (pd_wait && !(md_vld && md_data == pd_d && md_last == pd_l)) hold_bad++;
            pm_wait = mc_vld && !mc_rdy; pm_a = mc_addr; pm_s = mc_size;
            pd_wait = md_vld && !md_rdy; pd_d = md_data; pd_l = md_last;
            if (mc_vld && mc_rdy) begin mc_cnt++; mc_a = mc_addr; mc_s = mc_size; end
            if (md_vld && md_rdy) begin
                for (int i = 0; i < 8; i++) cap_b.push_back(md_data[i*8 +: 8]);
                cap_last.push_back(md_last);
            end
            if (rsp_vld && rsp_rdy) begin
                rsp_b = rsp_bytes; rsp_e = rsp_end; rsp_s = rsp_stream;
                rsp_cnt++;
                busy = 0;
            end
        end else begin
            pm_wait = 0; pd_wait = 0;
        end
    end

    // input beat driver and ready toggling
    initial begin
        logic [NS-1:0] hs;
        forever begin
            @(negedge clk);
            hs = in_vld & in_rdy;
            @(posedge clk); #2;
            lfsr    = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            mc_rdy  = lfsr[0] | lfsr[5];
            md_rdy  = lfsr[2] | lfsr[7];
            rsp_rdy = lfsr[3] | lfsr[9];
            for (int s = 0; s < NS; s++) begin
                if (hs[s]) void'(dq[s].pop_front());
                if (dq[s].size() > 0 && (in_vld[s] || lfsr[11+s])) begin
                    in_vld[s]            = 1'b1;
                    in_data[s*64 +: 64]  = dq[s][0].d;
                    in_nbytes[s*4 +: 4]  = 4'(dq[s][0].n);
                    in_last[s]           = dq[s][0].last;
                    in_tmo[s]            = dq[s][0].tmo;
                    in_trig[s]           = dq[s][0].trig;
                end else begin
                    in_vld[s] = 1'b0;
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        int lims [8] = '{1, 3, 7, 8, 9, 16, 17, 30};
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(cmd_rdy == 1'b1, "R11 reset cmd_rdy", cmd_rdy, 1);
        chk({mc_vld, md_vld, rsp_vld} == 3'b000, "R11 reset valids", {mc_vld, md_vld, rsp_vld}, 0);
        chk(in_rdy == '0, "R11 reset input readies", in_rdy, 0);
        @(posedge clk); #2 rst = 1'b0;

        // sweep: every beat size against limits across lane and beat boundaries
        for (int b = 1; b <= 8; b++) begin
            for (int mi = 0; mi < 8; mi++) begin
                int s = (b + mi) % 2;
                while (pending(s) < lims[mi]) push_beat(s, b, 0, 0, 0);
                run_cmd(s, 32'h1000 * (b * 8 + mi), lims[mi], "sweep");
            end
        end
        for (int s = 0; s < NS; s++)
            if (pending(s) > 0) run_cmd(s, 32'h0009_0000 + s, pending(s), "drain R4");

        // zero-byte timeout, without and with held bytes (R5, R6, R4)
        for (int k = 0; k < 4; k++) push_beat(0, 8, 0, 0, 0);
        run_cmd(0, 32'h0123_0000, 30, "split R3");
        push_beat(0, 0, 1, 1, 0);
        run_cmd(0, 32'h0123_1000, 32, "held+tmo R4 R5");
        push_beat(0, 0, 1, 1, 0);
        run_cmd(0, 32'h0123_2000, 32, "empty tmo R5 R6");
        for (int k = 0; k < 4; k++) push_beat(0, 8, 0, 0, 0);
        run_cmd(0, 32'h0123_3000, 32, "full R3");

        // frame ends (R7)
        push_beat(1, 5, 1, 0, 1);
        run_cmd(1, 32'h0200_0000, 16, "trig R7");
        push_beat(1, 8, 1, 1, 0);
        run_cmd(1, 32'h0200_1000, 3, "split last R7");
        run_cmd(1, 32'h0200_2000, 10, "held last R7");

        // zero limit and full staging buffer
        run_cmd(0, 32'h0300_0000, 0, "zero max R6");
        for (int k = 0; k < 8; k++) push_beat(0, 8, 0, 0, 0);
        run_cmd(0, 32'h0300_1000, 64, "buffer full R1");

        // reset while bytes are held (R11)
        push_beat(0, 8, 0, 0, 0);
        run_cmd(0, 32'h0400_0000, 3, "pre-reset R4");
        @(posedge clk); #2 rst = 1'b1;
        repeat (2) @(posedge clk);
        #2 rst = 1'b0;
        void'(mq[0].pop_front());
        push_beat(0, 4, 1, 1, 0);
        run_cmd(0, 32'h0400_1000, 16, "post-reset R11");

        chk(hold_bad == 0, "R9 payload held under backpressure", hold_bad, 0);
        chk(rdy_bad == 0, "R13 input ready selection", rdy_bad, 0);
        chk(busy_bad == 0, "R2 request ready while busy", busy_bad, 0);
        finish_run();
    end

endmodule